// File: doc/BRIEF.md
# Oversampled Serial Receiver with Length-Aware Break Detection

This block takes one asynchronous serial line, samples it at sixteen times the bit rate, and recovers characters of eight, nine or ten data bits followed by one or two stop bits. A received character is placed in a single holding register. A full flag marks that register as occupied until the consumer reads it. The block also reports a receiver-busy indication, an overrun condition, and the presence of a break on the line.

A break is a line held low for longer than any legal character can be. The number of low bit times needed depends on the character format. A long-break control adds a further margin. The caller supplies a single-cycle enable at sixteen times the bit rate, the serial line, and four static format controls. It reads the held character by pulsing a read strobe.

Top module: `uart_rx_brk`

## Requirements
- R1: A falling edge on the line starts a start-bit check at the eighth oversample tick. If the line is low there, `rx_active` goes to 1. A low pulse shorter than half a bit is ignored: `rx_active` stays 0 and nothing is stored.
- R2: `rx_active` returns to 0 by itself once the receiver finds the line high again, either at the last stop-bit sample of a normal character or after a break has ended.
- R3: The number of data bits is 10 when `ten_bit`=1, whatever `nine_bit` is. It is 9 when only `nine_bit`=1, and 8 otherwise. `two_stop`=1 selects two stop bits. Data arrives least significant bit first. It is presented right-justified on `rx_data`, and the unused upper bits read 0.
- R4: `rx_full` sets only when the last stop bit of a character has been sampled. While a character is still arriving, `rx_full` keeps its previous value.
- R5: A one-cycle pulse on `rd_strobe` clears `rx_full`.
- R6: If a character completes while `rx_full`=1 and no read happens in that cycle, `overrun` goes to 1. The new character is dropped, and `rx_data` keeps the earlier character.
- R7: A one-cycle pulse on `ovr_clr` clears `overrun`. Reading the data does not clear it.
- R8: With `long_brk`=0, `brk_det` sets when the count of consecutive low samples, counted from the start bit, reaches the frame length: 10, 11, 12 or 13. The frame length is one start bit plus the data bits plus the stop bits.
- R9: With `long_brk`=1, the thresholds become 11 for a 10-bit frame, 12 for an 11-bit frame, 14 for a 12-bit frame and 15 for a 13-bit frame. One low bit fewer than the threshold does not set `brk_det`.
- R10: A frame whose every sample is low is never stored as a character. `brk_det` stays 1 until the line returns high and then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Single-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | Select nine data bits |
| ten_bit | input | 1 | Select ten data bits (overrides nine_bit) |
| two_stop | input | 1 | Select two stop bits |
| long_brk | input | 1 | Select the longer break threshold |
| rd_strobe | input | 1 | Read of the held character; clears rx_full |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 10 | Held character, right-justified |
| rx_active | output | 1 | Receiver busy with a character or break |
| rx_full | output | 1 | Holding register occupied |
| overrun | output | 1 | A character was lost to a full holding register |
| brk_det | output | 1 | Break present on the line |

## Verification
The hardest case to reach is the exact break boundary. Here the line must stay low for exactly one bit fewer than the threshold, and then for exactly the threshold, in each of the eight formats with and without the long-break margin. In short mode, one bit fewer yields a stored all-zero character. In long mode, it yields a dropped all-low frame. The bench holds the line low for a computed number of whole bit times and checks `brk_det` just before and just after the last qualifying sample. Overrun is reached by sending a second character with no read between the two, and `rx_full` is checked while that second character is still in flight.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DMAX = 10;

    typedef logic [4:0] bcount_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RUN,
        ST_BRK,
        ST_WAITHI
    } rx_state_e;

    function automatic bcount_t data_bits(input logic nine, input logic ten);
        if (ten)       return 5'd10;
        else if (nine) return 5'd9;
        else           return 5'd8;
    endfunction

    function automatic bcount_t frame_bits(input logic nine, input logic ten,
                                           input logic two);
        return 5'd1 + data_bits(nine, ten) + (two ? 5'd2 : 5'd1);
    endfunction

    function automatic bcount_t brk_limit(input logic nine, input logic ten,
                                          input logic two, input logic lng);
        bcount_t n;
        n = frame_bits(nine, ten, two);
        if (!lng)          return n;
        else if (n >= 5'd12) return n + 5'd2;
        else               return n + 5'd1;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            rx_i,
    input  logic            nine_i,
    input  logic            ten_i,
    input  logic            two_i,
    input  logic            long_i,
    output logic            done_o,
    output logic            brk_set_o,
    output logic            brk_clr_o,
    output logic [DMAX-1:0] data_o,
    output logic            active_o
);
    localparam int TW = $clog2(OSR);
    localparam logic [TW-1:0] HALF = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OSR - 1);
    localparam int IW = $clog2(DMAX);

    typedef struct packed {
        rx_state_e       state;
        logic [TW-1:0]   tcnt;
        bcount_t         bidx;
        bcount_t         lowcnt;
        logic            all_low;
        logic [DMAX-1:0] shreg;
        logic            active;
    } frame_t;

    frame_t  fr_d, fr_q;
    bcount_t dbits, fbits, lim;
    logic [IW-1:0] widx;

    always_comb begin
        dbits = data_bits(nine_i, ten_i);
        fbits = frame_bits(nine_i, ten_i, two_i);
        lim   = brk_limit(nine_i, ten_i, two_i, long_i);
        widx  = IW'(fr_q.bidx - 5'd1);
    end

    always_comb begin
        fr_d      = fr_q;
        done_o    = 1'b0;
        brk_set_o = 1'b0;
        brk_clr_o = 1'b0;
        case (fr_q.state)
            ST_IDLE: begin
                fr_d.active = 1'b0;
                if (tick_i && !rx_i) begin
                    fr_d.state = ST_START;
                    fr_d.tcnt  = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (fr_q.tcnt == HALF) begin
                        if (!rx_i) begin
                            fr_d.state   = ST_RUN;
                            fr_d.tcnt    = '0;
                            fr_d.bidx    = 5'd1;
                            fr_d.lowcnt  = 5'd1;
                            fr_d.all_low = 1'b1;
                            fr_d.shreg   = '0;
                            fr_d.active  = 1'b1;
                        end else begin
                            fr_d.state = ST_IDLE;
                        end
                    end else begin
                        fr_d.tcnt = fr_q.tcnt + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (tick_i) begin
                    if (fr_q.tcnt == LAST) begin
                        fr_d.tcnt = '0;
                        if (fr_q.bidx <= dbits) fr_d.shreg[widx] = rx_i;
                        if (!rx_i) fr_d.lowcnt  = fr_q.lowcnt + 5'd1;
                        else       fr_d.all_low = 1'b0;
                        if (fr_q.bidx == fbits - 5'd1) begin
                            if (fr_d.all_low) begin
                                if (fr_d.lowcnt >= lim) begin
                                    brk_set_o  = 1'b1;
                                    fr_d.state = ST_WAITHI;
                                end else begin
                                    fr_d.state = ST_BRK;
                                end
                            end else begin
                                done_o = 1'b1;
                                if (rx_i) begin
                                    fr_d.state  = ST_IDLE;
                                    fr_d.active = 1'b0;
                                end else begin
                                    fr_d.state = ST_WAITHI;
                                end
                            end
                        end else begin
                            fr_d.bidx = fr_q.bidx + 5'd1;
                        end
                    end else begin
                        fr_d.tcnt = fr_q.tcnt + 1'b1;
                    end
                end
            end
            ST_BRK: begin
                if (tick_i) begin
                    if (fr_q.tcnt == LAST) begin
                        fr_d.tcnt = '0;
                        if (!rx_i) begin
                            fr_d.lowcnt = fr_q.lowcnt + 5'd1;
                            if (fr_d.lowcnt >= lim) begin
                                brk_set_o  = 1'b1;
                                fr_d.state = ST_WAITHI;
                            end
                        end else begin
                            fr_d.state  = ST_IDLE;
                            fr_d.active = 1'b0;
                        end
                    end else begin
                        fr_d.tcnt = fr_q.tcnt + 1'b1;
                    end
                end
            end
            ST_WAITHI: begin
                if (rx_i) begin
                    fr_d.state  = ST_IDLE;
                    fr_d.active = 1'b0;
                    brk_clr_o   = 1'b1;
                end
            end
            default: fr_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q.state   <= ST_IDLE;
            fr_q.tcnt    <= '0;
            fr_q.bidx    <= '0;
            fr_q.lowcnt  <= '0;
            fr_q.all_low <= 1'b0;
            fr_q.shreg   <= '0;
            fr_q.active  <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign data_o   = fr_q.shreg;
    assign active_o = fr_q.active;

    // R1: busy only ever begins out of the start-bit check
    a_r1_active_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.active) |-> $past(fr_q.state == ST_START));

    // R10: a break is only declared on a low sample, never together with a character
    a_r10_brk_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_set_o |-> (!rx_i && !done_o));

    // R2: leaving the busy state happens only with the line seen high
    a_r2_idle_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fr_q.active) |-> $past(rx_i));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_i,
    input  logic [DMAX-1:0] fdata_i,
    input  logic            brk_set_i,
    input  logic            brk_clr_i,
    input  logic            rd_i,
    input  logic            ovr_clr_i,
    output logic [DMAX-1:0] data_o,
    output logic            full_o,
    output logic            ovr_o,
    output logic            brk_o
);
    typedef struct packed {
        logic            full;
        logic            ovr;
        logic            brk;
        logic [DMAX-1:0] data;
    } flags_t;

    flags_t fl_d, fl_q;
    logic   full_after_rd;

    always_comb begin
        fl_d          = fl_q;
        full_after_rd = fl_q.full & ~rd_i;
        fl_d.full     = full_after_rd;
        if (ovr_clr_i) fl_d.ovr = 1'b0;
        if (done_i) begin
            if (full_after_rd) begin
                fl_d.ovr = 1'b1;
            end else begin
                fl_d.full = 1'b1;
                fl_d.data = fdata_i;
            end
        end
        if (brk_set_i)      fl_d.brk = 1'b1;
        else if (brk_clr_i) fl_d.brk = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign data_o = fl_q.data;
    assign full_o = fl_q.full;
    assign ovr_o  = fl_q.ovr;
    assign brk_o  = fl_q.brk;

    // R4: the full flag rises only after a completed character
    a_r4_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.full) |-> $past(done_i));

    // R5: a read with no arriving character empties the holding register
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> !fl_q.full);

    // R6: a character landing on a full register is dropped and flagged
    a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && fl_q.full && !rd_i) |=> (fl_q.ovr && $stable(fl_q.data)));

    // R7: the overrun flag is not cleared by a read
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ovr && !ovr_clr_i) |=> fl_q.ovr);
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic        rxd,
    input  logic        nine_bit,
    input  logic        ten_bit,
    input  logic        two_stop,
    input  logic        long_brk,
    input  logic        rd_strobe,
    input  logic        ovr_clr,
    output logic [9:0]  rx_data,
    output logic        rx_active,
    output logic        rx_full,
    output logic        overrun,
    output logic        brk_det
);
    logic            rx_s;
    logic            done, brk_set, brk_clr;
    logic [DMAX-1:0] fdata;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rx_frame #(.OSR(OSR)) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (baud_tick),
        .rx_i     (rx_s),
        .nine_i   (nine_bit),
        .ten_i    (ten_bit),
        .two_i    (two_stop),
        .long_i   (long_brk),
        .done_o   (done),
        .brk_set_o(brk_set),
        .brk_clr_o(brk_clr),
        .data_o   (fdata),
        .active_o (rx_active)
    );

    uart_rx_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done),
        .fdata_i  (fdata),
        .brk_set_i(brk_set),
        .brk_clr_i(brk_clr),
        .rd_i     (rd_strobe),
        .ovr_clr_i(ovr_clr),
        .data_o   (rx_data),
        .full_o   (rx_full),
        .ovr_o    (overrun),
        .brk_o    (brk_det)
    );

    // R10: a break is reported only while the receiver is busy
    a_r10_brk_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_det) |-> rx_active);
endmodule

// File: tb/test_uart_rx_brk.sv
module test_uart_rx_brk;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0, ten_bit = 1'b0, two_stop = 1'b0, long_brk = 1'b0;
    logic       rd_strobe = 1'b0, ovr_clr = 1'b0;
    logic [9:0] rx_data;
    logic       rx_active, rx_full, overrun, brk_det;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

    uart_rx_brk i_uart_rx_brk (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .nine_bit(nine_bit), .ten_bit(ten_bit), .two_stop(two_stop),
        .long_brk(long_brk), .rd_strobe(rd_strobe), .ovr_clr(ovr_clr),
        .rx_data(rx_data), .rx_active(rx_active), .rx_full(rx_full),
        .overrun(overrun), .brk_det(brk_det)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        wclk(BIT_CLKS);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        wclk(1);
        rd_strobe = 1'b0;
        wclk(1);
    endtask

    function automatic int dbits_of(input int f);
        return f[1] ? 10 : (f[0] ? 9 : 8);
    endfunction

    function automatic int frame_of(input int f);
        return 1 + dbits_of(f) + (f[2] ? 2 : 1);
    endfunction

    function automatic int limit_of(input int f, input bit lng);
        int n;
        n = frame_of(f);
        if (!lng) return n;
        return (n >= 12) ? n + 2 : n + 1;
    endfunction

    // one character; checks rx_full and rx_active while it is still arriving
    task automatic send_char(input int v, input int f, input bit prev_full);
        int d;
        d = dbits_of(f);
        drive_bit(1'b0);
        for (int i = 0; i < d; i++) begin
            drive_bit(v[i]);
            if (i == 2) begin
                chk(rx_full == prev_full, "R4 full unchanged mid-character", rx_full, prev_full);
                chk(rx_active == 1'b1, "R1 active during character", rx_active, 1);
            end
        end
        drive_bit(1'b1);
        if (f[2]) drive_bit(1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int vals[5];
        vals = '{10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h0A5};
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        chk(rx_full == 0 && rx_active == 0 && overrun == 0 && brk_det == 0 && rx_data == 0,
            "R2 reset state", {rx_full, rx_active, overrun, brk_det}, 0);

        // R1: short glitch is not a start bit
        rxd = 1'b0;
        wclk(8);
        rxd = 1'b1;
        wclk(2 * BIT_CLKS);
        chk(rx_active == 0, "R1 glitch ignored active", rx_active, 0);
        chk(rx_full == 0, "R1 glitch ignored full", rx_full, 0);

        // R3/R4/R5 sweep over all formats and patterns
        for (int f = 0; f < 8; f++) begin
            nine_bit = f[0]; ten_bit = f[1]; two_stop = f[2];
            for (int k = 0; k < 5; k++) begin
                int exp;
                exp = vals[k] & ((1 << dbits_of(f)) - 1);
                send_char(vals[k], f, 1'b0);
                chk(rx_full == 1, "R4 full after stop", rx_full, 1);
                chk(rx_data == 10'(exp), "R3 data format", rx_data, exp);
                chk(rx_active == 0, "R2 active clears after stop", rx_active, 0);
                do_read();
                chk(rx_full == 0, "R5 read clears full", rx_full, 0);
            end
        end

        // R6/R7 overrun
        nine_bit = 0; ten_bit = 0; two_stop = 0;
        send_char(8'h5A, 0, 1'b0);
        send_char(8'hC3, 0, 1'b1);
        chk(overrun == 1, "R6 overrun set", overrun, 1);
        chk(rx_data == 10'h05A, "R6 first character kept", rx_data, 10'h05A);
        chk(rx_full == 1, "R6 still full", rx_full, 1);
        do_read();
        chk(rx_full == 0, "R5 read after overrun", rx_full, 0);
        chk(overrun == 1, "R7 read leaves overrun", overrun, 1);
        ovr_clr = 1'b1;
        wclk(1);
        ovr_clr = 1'b0;
        wclk(1);
        chk(overrun == 0, "R7 clear overrun", overrun, 0);

        // R8/R9/R10 break thresholds
        for (int lng = 0; lng < 2; lng++) begin
            for (int f = 0; f < 8; f++) begin
                int lim;
                nine_bit = f[0]; ten_bit = f[1]; two_stop = f[2]; long_brk = lng[0];
                lim = limit_of(f, lng[0]);
                // one bit short of the threshold
                for (int i = 0; i < lim - 1; i++) drive_bit(1'b0);
                drive_bit(1'b1);
                drive_bit(1'b1);
                if (lng == 0) begin
                    chk(brk_det == 0, "R8 no break one bit short", brk_det, 0);
                    chk(rx_full == 1 && rx_data == 0, "R8 short low frame is a zero char",
                        rx_data, 0);
                end else begin
                    chk(brk_det == 0, "R9 no break one bit short", brk_det, 0);
                    chk(rx_full == 0, "R10 all-low frame not stored", rx_full, 0);
                end
                if (rx_full) do_read();
                // exactly at the threshold
                for (int i = 0; i < lim - 1; i++) drive_bit(1'b0);
                chk(brk_det == 0, lng ? "R9 not yet at limit-1" : "R8 not yet at limit-1",
                    brk_det, 0);
                drive_bit(1'b0);
                chk(brk_det == 1, lng ? "R9 break at limit" : "R8 break at limit", brk_det, 1);
                chk(rx_full == 0, "R10 break not stored", rx_full, 0);
                chk(rx_active == 1, "R2 active during break", rx_active, 1);
                rxd = 1'b1;
                wclk(6);
                chk(brk_det == 0, "R10 break clears on high", brk_det, 0);
                chk(rx_active == 0, "R2 active clears after break", rx_active, 0);
                wclk(BIT_CLKS);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule